// File: doc/BRIEF.md
# Integer Multiply-Divide Unit with HI/LO Interlock

This block is the integer multiply and divide engine that sits next to the main ALU of a 64-bit core. It takes an operation code and two 64-bit operands. It computes 32-bit and 64-bit products and quotients, in signed and unsigned forms, and it can also add a 32-bit signed product to the HI:LO accumulator or subtract one from it. Results land in two architectural registers, HI and LO, which the pipeline reads through `hiOut` and `loOut`.

Every operation class has a fixed latency and a fixed repeat interval in pipeline clocks. The unit tracks both with down-counters. If the pipeline asks to read HI or LO before the pending result is written, `stallHilo` rises. If it presents a new operation for this unit before the repeat interval has run out, `stallBusy` rises and the operation waits. Instructions meant for other units are never held up.

A slow-multiply input adds one cycle of latency and one cycle of repeat to every multiply-class operation. Divides are iterative at one quotient bit per cycle, and the latency counter pads them to their exact stated latency.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `hiOut` and `loOut` are zero and neither `stallHilo` nor `stallBusy` is asserted.
- R2: `opCode` 0 is a signed 32-bit multiply and 1 is an unsigned 32-bit multiply, both of the low 32 bits of `opA` and `opB`. HI receives the upper word of the 64-bit product and LO the lower word, each sign-extended from bit 31 to 64 bits.
- R3: `opCode` 2 is a signed 64-bit multiply and 3 is an unsigned one. HI receives bits 127:64 of the 128-bit product and LO receives bits 63:0.
- R4: `opCode` 4 and 5 are signed and unsigned 32-bit divides of the low words, with results sign-extended from bit 31. `opCode` 6 and 7 are signed and unsigned 64-bit divides. LO receives the quotient, truncated toward zero, and HI receives the remainder, which takes the sign of the dividend. The most negative dividend divided by minus one gives the most negative quotient and a zero remainder.
- R5: When the divisor (the low word for 32-bit divides) is zero, LO becomes all ones and HI becomes the dividend (sign-extended low word for 32-bit divides).
- R6: `opCode` 8 adds and `opCode` 9 subtracts the signed 32-bit product of the low words to or from the 64-bit accumulator formed by HI bits 31:0 (upper half) and LO bits 31:0 (lower half). The new upper half goes to HI and the new lower half to LO, each sign-extended from bit 31.
- R7: Latency L (in clocks) is 4 for codes 0–1, 6 for 2–3, 36 for 4–5, 68 for 6–7, 3 for 8 and 4 for 9. Suppose an operation is accepted in cycle c. A HI or LO read request in cycles c+1 through c+L-1 raises `stallHilo`. From cycle c+L the new result is on `hiOut`/`loOut` and a read does not stall. A read in cycle c itself does not stall and sees the previous value.
- R8: Repeat interval R is 3 for codes 0–1, 5 for 2–3, 36 for 4–5, 68 for 6–7, 2 for 8 and 3 for 9. A new operation with code 0–9 presented in cycles c+1 through c+R-1 raises `stallBusy` and is not accepted. If held, it is accepted in cycle c+R.
- R9: While `slowMul` is high in the accepting cycle, codes 0–3, 8 and 9 get L+1 and R+1. Divides keep their timing.
- R10: `stallHilo` is asserted only while `rdHi` or `rdLo` is high. Codes 10–15 never raise `stallBusy`, even while the unit is busy, and leave HI and LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An instruction is presented this cycle |
| opCode | input | 4 | Operation code (0–9 for this unit) |
| opA | input | 64 | First operand / dividend |
| opB | input | 64 | Second operand / divisor |
| slowMul | input | 1 | Adds one cycle to multiply-class latency and repeat |
| rdHi | input | 1 | Pipeline wants to read HI this cycle |
| rdLo | input | 1 | Pipeline wants to read LO this cycle |
| hiOut | output | 64 | HI register |
| loOut | output | 64 | LO register |
| stallHilo | output | 1 | Early HI/LO read must wait |
| stallBusy | output | 1 | New unit operation must wait |

## Verification
The bench holds a read request from the cycle after issue until the result appears, and it counts the stalled cycles exactly. A latency counter that is off by one would either release stale HI/LO values or stall one cycle too long. Back-to-back issue measures the `stallBusy` window, including slow-multiply mode and divides, which must stay unaffected. A design that applied the extra cycle to divides or lost it on multiply-add would miscount here.

Value corner cases include zero divisors, the most negative value divided by minus one, unsigned all-ones operands and multiply-add chains that carry across the 32-bit accumulator boundary. A wrong sign rule, wrong sign extension or a stale accumulator read would each show up as a HI/LO mismatch. An operation code outside the unit is presented while a divide is in flight; holding it up or letting it touch HI/LO would break R10.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [3:0] {
    OP_MUL32S = 4'd0,
    OP_MUL32U = 4'd1,
    OP_MUL64S = 4'd2,
    OP_MUL64U = 4'd3,
    OP_DIV32S = 4'd4,
    OP_DIV32U = 4'd5,
    OP_DIV64S = 4'd6,
    OP_DIV64U = 4'd7,
    OP_MACC   = 4'd8,
    OP_MSUBT  = 4'd9
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands, seed divider
    logic divStep;  // one restoring-division iteration
    logic write;    // commit result into HI/LO
  } mdStrobe_t;

  function automatic logic isUnitOp(logic [3:0] c);
    return c <= 4'd9;
  endfunction

  function automatic logic isMulClass(logic [3:0] c);
    return (c <= 4'd3) || (c == 4'd8) || (c == 4'd9);
  endfunction

  function automatic logic isDivOp(logic [3:0] c);
    return (c >= 4'd4) && (c <= 4'd7);
  endfunction

  function automatic logic isWideOp(logic [3:0] c);
    return (c == 4'd2) || (c == 4'd3) || (c == 4'd6) || (c == 4'd7);
  endfunction

  function automatic logic isSignedOp(logic [3:0] c);
    return (c == 4'd0) || (c == 4'd2) || (c == 4'd4) || (c == 4'd6) ||
           (c == 4'd8) || (c == 4'd9);
  endfunction

endpackage

// File: rtl/muldiv_divstep.sv
module muldiv_divstep #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] remIn,
  input  logic [XLEN-1:0] quoIn,
  input  logic [XLEN-1:0] divisor,
  output logic [XLEN-1:0] remOut,
  output logic [XLEN-1:0] quoOut
);
  logic [XLEN:0] remShift;
  logic [XLEN:0] diff;
  logic          fits;

  always_comb begin
    remShift = {remIn, quoIn[XLEN-1]};
    diff     = remShift - {1'b0, divisor};
    fits     = remShift >= {1'b0, divisor};
    remOut   = fits ? diff[XLEN-1:0] : remShift[XLEN-1:0];
    quoOut   = {quoIn[XLEN-2:0], fits};
  end
endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MUL32_LAT = 4,
  parameter int MUL32_REP = 3,
  parameter int MUL64_LAT = 6,
  parameter int MUL64_REP = 5,
  parameter int DIV32_LAT = 36,
  parameter int DIV32_REP = 36,
  parameter int DIV64_LAT = 68,
  parameter int DIV64_REP = 68,
  parameter int MACC_LAT  = 3,
  parameter int MACC_REP  = 2,
  parameter int MSUB_LAT  = 4,
  parameter int MSUB_REP  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       slowMul,
  input  logic       rdHi,
  input  logic       rdLo,
  output logic       stallHilo,
  output logic       stallBusy,
  output mdStrobe_t  strobe
);
  localparam int HALF    = XLEN / 2;
  localparam int CNT_MAX = MUL32_LAT + MUL64_LAT + DIV32_LAT + DIV64_LAT +
                           MACC_LAT + MSUB_LAT + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int IW      = $clog2(XLEN + 1);

  logic [CW-1:0] latLeft, repLeft;
  logic [IW-1:0] iterLeft;
  logic [CW-1:0] opLat, opRep;
  logic [IW-1:0] opIter;
  logic          unitOp, accept;

  always_comb begin
    case (opCode)
      OP_MUL32S, OP_MUL32U: begin opLat = CW'(MUL32_LAT); opRep = CW'(MUL32_REP); end
      OP_MUL64S, OP_MUL64U: begin opLat = CW'(MUL64_LAT); opRep = CW'(MUL64_REP); end
      OP_DIV32S, OP_DIV32U: begin opLat = CW'(DIV32_LAT); opRep = CW'(DIV32_REP); end
      OP_DIV64S, OP_DIV64U: begin opLat = CW'(DIV64_LAT); opRep = CW'(DIV64_REP); end
      OP_MACC:              begin opLat = CW'(MACC_LAT);  opRep = CW'(MACC_REP);  end
      OP_MSUBT:             begin opLat = CW'(MSUB_LAT);  opRep = CW'(MSUB_REP);  end
      default:              begin opLat = CW'(1);         opRep = CW'(1);         end
    endcase
    if (slowMul && isMulClass(opCode)) begin
      opLat = opLat + CW'(1);
      opRep = opRep + CW'(1);
    end
    if (isDivOp(opCode))
      opIter = isWideOp(opCode) ? IW'(XLEN) : IW'(HALF);
    else
      opIter = '0;
  end

  assign unitOp    = opValid && isUnitOp(opCode);
  assign stallBusy = unitOp && (repLeft != '0);
  assign accept    = unitOp && (repLeft == '0);
  assign stallHilo = (rdHi || rdLo) && (latLeft != '0);

  assign strobe.load    = accept;
  assign strobe.divStep = iterLeft != '0;
  assign strobe.write   = latLeft == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latLeft  <= '0;
      repLeft  <= '0;
      iterLeft <= '0;
    end else begin
      if (accept)                latLeft <= opLat - CW'(1);
      else if (latLeft != '0)    latLeft <= latLeft - CW'(1);

      if (accept)                repLeft <= opRep - CW'(1);
      else if (repLeft != '0)    repLeft <= repLeft - CW'(1);

      if (accept)                iterLeft <= opIter;
      else if (iterLeft != '0)   iterLeft <= iterLeft - IW'(1);
    end
  end
endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mdStrobe_t       strobe,
  input  logic [3:0]      opCode,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] hiOut,
  output logic [XLEN-1:0] loOut
);
  localparam int HALF = XLEN / 2;

  logic [3:0]      opReg;
  logic [XLEN-1:0] aReg, bReg;
  logic [XLEN-1:0] remR, quoR, dvsR;
  logic            negQ, negR;
  logic [XLEN-1:0] hiR, loR;

  // operand conditioning at issue
  logic            ldSigned, ldWide, aNeg, bNeg;
  logic [XLEN-1:0] magA, magB, quoInit;
  logic [HALF-1:0] aLoNeg, bLoNeg;

  always_comb begin
    ldSigned = isSignedOp(opCode);
    ldWide   = isWideOp(opCode);
    aNeg     = ldSigned && (ldWide ? opA[XLEN-1] : opA[HALF-1]);
    bNeg     = ldSigned && (ldWide ? opB[XLEN-1] : opB[HALF-1]);
    aLoNeg   = HALF'(0) - opA[HALF-1:0];
    bLoNeg   = HALF'(0) - opB[HALF-1:0];
    if (ldWide) begin
      magA = aNeg ? (XLEN'(0) - opA) : opA;
      magB = bNeg ? (XLEN'(0) - opB) : opB;
    end else begin
      magA = {{HALF{1'b0}}, aNeg ? aLoNeg : opA[HALF-1:0]};
      magB = {{HALF{1'b0}}, bNeg ? bLoNeg : opB[HALF-1:0]};
    end
    quoInit = ldWide ? magA : (magA << HALF);
  end

  logic [XLEN-1:0] stepRem, stepQuo;

  muldiv_divstep #(.XLEN(XLEN)) u_divstep (
    .remIn  (remR),
    .quoIn  (quoR),
    .divisor(dvsR),
    .remOut (stepRem),
    .quoOut (stepQuo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opReg <= '0;
      aReg  <= '0;
      bReg  <= '0;
      remR  <= '0;
      quoR  <= '0;
      dvsR  <= '0;
      negQ  <= 1'b0;
      negR  <= 1'b0;
    end else if (strobe.load) begin
      opReg <= opCode;
      aReg  <= opA;
      bReg  <= opB;
      remR  <= '0;
      quoR  <= quoInit;
      dvsR  <= magB;
      negQ  <= aNeg ^ bNeg;
      negR  <= aNeg;
    end else if (strobe.divStep) begin
      remR  <= stepRem;
      quoR  <= stepQuo;
    end
  end

  // result formation at commit
  logic            rSigned;
  logic [XLEN-1:0] nA, nB, nP;
  logic [2*XLEN-1:0] wA, wB, wP;
  logic [XLEN-1:0] accNow, accNew, accProd;
  logic [HALF-1:0] q32, r32;
  logic [XLEN-1:0] q64, r64;
  logic [XLEN-1:0] hiNext, loNext;

  always_comb begin
    rSigned = isSignedOp(opReg);
    nA  = {{HALF{rSigned & aReg[HALF-1]}}, aReg[HALF-1:0]};
    nB  = {{HALF{rSigned & bReg[HALF-1]}}, bReg[HALF-1:0]};
    nP  = nA * nB;
    wA  = {{XLEN{rSigned & aReg[XLEN-1]}}, aReg};
    wB  = {{XLEN{rSigned & bReg[XLEN-1]}}, bReg};
    wP  = wA * wB;
    accNow  = {hiR[HALF-1:0], loR[HALF-1:0]};
    accProd = nP;
    accNew  = (opReg == OP_MSUBT) ? (accNow - accProd) : (accNow + accProd);
    q32 = negQ ? (HALF'(0) - quoR[HALF-1:0]) : quoR[HALF-1:0];
    r32 = negR ? (HALF'(0) - remR[HALF-1:0]) : remR[HALF-1:0];
    q64 = negQ ? (XLEN'(0) - quoR) : quoR;
    r64 = negR ? (XLEN'(0) - remR) : remR;

    hiNext = hiR;
    loNext = loR;
    case (opReg)
      OP_MUL32S, OP_MUL32U: begin
        hiNext = {{HALF{nP[XLEN-1]}}, nP[XLEN-1:HALF]};
        loNext = {{HALF{nP[HALF-1]}}, nP[HALF-1:0]};
      end
      OP_MUL64S, OP_MUL64U: begin
        hiNext = wP[2*XLEN-1:XLEN];
        loNext = wP[XLEN-1:0];
      end
      OP_MACC, OP_MSUBT: begin
        hiNext = {{HALF{accNew[XLEN-1]}}, accNew[XLEN-1:HALF]};
        loNext = {{HALF{accNew[HALF-1]}}, accNew[HALF-1:0]};
      end
      OP_DIV32S, OP_DIV32U: begin
        if (bReg[HALF-1:0] == '0) begin
          hiNext = {{HALF{aReg[HALF-1]}}, aReg[HALF-1:0]};
          loNext = '1;
        end else begin
          hiNext = {{HALF{r32[HALF-1]}}, r32};
          loNext = {{HALF{q32[HALF-1]}}, q32};
        end
      end
      OP_DIV64S, OP_DIV64U: begin
        if (bReg == '0) begin
          hiNext = aReg;
          loNext = '1;
        end else begin
          hiNext = r64;
          loNext = q64;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiR <= '0;
      loR <= '0;
    end else if (strobe.write) begin
      hiR <= hiNext;
      loR <= loNext;
    end
  end

  assign hiOut = hiR;
  assign loOut = loR;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MUL32_LAT = 4,
  parameter int MUL32_REP = 3,
  parameter int MUL64_LAT = 6,
  parameter int MUL64_REP = 5,
  parameter int DIV32_LAT = 36,
  parameter int DIV32_REP = 36,
  parameter int DIV64_LAT = 68,
  parameter int DIV64_REP = 68,
  parameter int MACC_LAT  = 3,
  parameter int MACC_REP  = 2,
  parameter int MSUB_LAT  = 4,
  parameter int MSUB_REP  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            opValid,
  input  logic [3:0]      opCode,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic            slowMul,
  input  logic            rdHi,
  input  logic            rdLo,
  output logic [XLEN-1:0] hiOut,
  output logic [XLEN-1:0] loOut,
  output logic            stallHilo,
  output logic            stallBusy
);
  mdStrobe_t ctrlStrobe;

  muldiv_ctrl #(
    .XLEN(XLEN),
    .MUL32_LAT(MUL32_LAT), .MUL32_REP(MUL32_REP),
    .MUL64_LAT(MUL64_LAT), .MUL64_REP(MUL64_REP),
    .DIV32_LAT(DIV32_LAT), .DIV32_REP(DIV32_REP),
    .DIV64_LAT(DIV64_LAT), .DIV64_REP(DIV64_REP),
    .MACC_LAT(MACC_LAT),   .MACC_REP(MACC_REP),
    .MSUB_LAT(MSUB_LAT),   .MSUB_REP(MSUB_REP)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .opCode   (opCode),
    .slowMul  (slowMul),
    .rdHi     (rdHi),
    .rdLo     (rdLo),
    .stallHilo(stallHilo),
    .stallBusy(stallBusy),
    .strobe   (ctrlStrobe)
  );

  muldiv_datapath #(.XLEN(XLEN)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(ctrlStrobe),
    .opCode(opCode),
    .opA   (opA),
    .opB   (opB),
    .hiOut (hiOut),
    .loOut (loOut)
  );
endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker
  import muldiv_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            opValid,
  input logic [3:0]      opCode,
  input logic            rdHi,
  input logic            rdLo,
  input logic [XLEN-1:0] hiOut,
  input logic [XLEN-1:0] loOut,
  input logic            stallHilo,
  input logic            stallBusy,
  input mdStrobe_t       strobe
);
  // R10: foreign opcodes are never held up
  assert_foreign_not_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode > 4'd9) |-> !stallBusy);

  // R10: interlock only on an actual read
  assert_stall_needs_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stallHilo |-> (rdHi || rdLo));

  // R8: every repeat interval is at least two cycles
  assert_repeat_blocks_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode <= 4'd9 && !stallBusy) |=>
      (!(opValid && opCode <= 4'd9) || stallBusy));

  // R7: the cycle after issue, HI/LO is not ready yet
  assert_early_read_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode <= 4'd9 && !stallBusy) |=> (!(rdHi || rdLo) || stallHilo));

  // R7: HI/LO move only after a commit strobe from control
  assert_hilo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.write |=> ($stable(hiOut) && $stable(loOut)));

  // R4: the divider is finished before its result is committed
  assert_div_done_before_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.write |-> !strobe.divStep);

  // R8: operands are captured only for an unstalled unit opcode
  assert_load_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |-> (opValid && opCode <= 4'd9 && !stallBusy));
endmodule

bind muldiv_unit muldiv_checker #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opValid  (opValid),
  .opCode   (opCode),
  .rdHi     (rdHi),
  .rdLo     (rdLo),
  .hiOut    (hiOut),
  .loOut    (loOut),
  .stallHilo(stallHilo),
  .stallBusy(stallBusy),
  .strobe   (ctrlStrobe)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [63:0] opA = '0, opB = '0;
  logic        slowMul = 1'b0;
  logic        rdHi = 1'b0, rdLo = 1'b0;
  logic [63:0] hiOut, loOut;
  logic        stallHilo, stallBusy;

  int checks = 0;
  int fails  = 0;
  logic [63:0] mHi = '0, mLo = '0;

  always #5 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .slowMul(slowMul), .rdHi(rdHi), .rdLo(rdLo),
    .hiOut(hiOut), .loOut(loOut), .stallHilo(stallHilo), .stallBusy(stallBusy)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mulClass(int op);
    return op <= 3 || op == 8 || op == 9;
  endfunction

  function automatic int expLat(int op, bit slow);
    int l;
    case (op)
      0, 1: l = 4;  2, 3: l = 6;  4, 5: l = 36;  6, 7: l = 68;
      8: l = 3;     default: l = 4;
    endcase
    return l + ((slow && mulClass(op)) ? 1 : 0);
  endfunction

  function automatic int expRep(int op, bit slow);
    int r;
    case (op)
      0, 1: r = 3;  2, 3: r = 5;  4, 5: r = 36;  6, 7: r = 68;
      8: r = 2;     default: r = 3;
    endcase
    return r + ((slow && mulClass(op)) ? 1 : 0);
  endfunction

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic string reqOf(int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 7: return "R4";
      default: return "R6";
    endcase
  endfunction

  // reference model of HI/LO update
  task automatic model(input int op, input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] sa, sb;
    logic [127:0] ua, ub, p128;
    longint p64, acc;
    logic [63:0] ma, mb, q, r;
    bit sg, wide, an, bn;
    case (op)
      0: begin p64 = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
               mHi = sx(p64[63:32]); mLo = sx(p64[31:0]); end
      1: begin p64 = longint'({32'b0, a[31:0]}) * longint'({32'b0, b[31:0]});
               mHi = sx(p64[63:32]); mLo = sx(p64[31:0]); end
      2: begin sa = $signed(a); sb = $signed(b); p128 = sa * sb;
               mHi = p128[127:64]; mLo = p128[63:0]; end
      3: begin ua = {64'b0, a}; ub = {64'b0, b}; p128 = ua * ub;
               mHi = p128[127:64]; mLo = p128[63:0]; end
      8, 9: begin
        acc = {mHi[31:0], mLo[31:0]};
        p64 = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
        acc = (op == 8) ? acc + p64 : acc - p64;
        mHi = sx(acc[63:32]); mLo = sx(acc[31:0]);
      end
      default: begin
        wide = op >= 6; sg = (op == 4 || op == 6);
        an = sg && (wide ? a[63] : a[31]);
        bn = sg && (wide ? b[63] : b[31]);
        if (wide) begin
          ma = an ? -a : a; mb = bn ? -b : b;
        end else begin
          ma = {32'b0, an ? -a[31:0] : a[31:0]};
          mb = {32'b0, bn ? -b[31:0] : b[31:0]};
        end
        if (mb == 0) begin
          mLo = '1; mHi = wide ? a : sx(a[31:0]);
        end else begin
          q = ma / mb; r = ma % mb;
          if (an ^ bn) q = -q;
          if (an) r = -r;
          mLo = wide ? q : sx(q[31:0]);
          mHi = wide ? r : sx(r[31:0]);
        end
      end
    endcase
  endtask

  // issue one op on an idle unit, hold a read and measure the interlock window
  task automatic runOp(input int op, input logic [63:0] a, input logic [63:0] b);
    int lat;
    bit ok;
    lat = expLat(op, slowMul);
    @(negedge clk);
    opValid = 1'b1; opCode = 4'(op); opA = a; opB = b;
    rdHi = 1'b1; rdLo = 1'b0;
    #1 check(!stallBusy && !stallHilo, "R7 issue cycle read no stall", {62'b0, stallBusy, stallHilo}, 64'd0);
    @(negedge clk);
    opValid = 1'b0;
    if ($urandom_range(1, 0) == 1) begin rdHi = 1'b0; rdLo = 1'b1; end
    ok = 1'b1;
    for (int k = 1; k < lat; k++) begin
      #1 if (!stallHilo) ok = 1'b0;
      @(negedge clk);
    end
    #1;
    model(op, a, b);
    check(ok && !stallHilo, (slowMul ? "R9 latency window" : "R7 latency window"),
          64'(lat), 64'(lat));
    check(hiOut == mHi, reqOf(op), hiOut, mHi);
    check(loOut == mLo, reqOf(op), loOut, mLo);
    rdHi = 1'b0; rdLo = 1'b0;
  endtask

  // issue op, then present op2 back to back and count busy cycles
  task automatic runRep(input int op, input int op2, input logic [63:0] a, input logic [63:0] b);
    int cnt;
    @(negedge clk);
    opValid = 1'b1; opCode = 4'(op); opA = a; opB = b;
    @(negedge clk);
    opCode = 4'(op2); opA = b; opB = a;
    cnt = 0;
    for (int g = 0; g < 200; g++) begin
      #1;
      if (!stallBusy) break;
      cnt++;
      @(negedge clk);
    end
    @(negedge clk);
    opValid = 1'b0;
    model(op, a, b);
    model(op2, b, a);
    check(cnt == expRep(op, slowMul) - 1, (slowMul ? "R9 repeat window" : "R8 repeat window"),
          64'(cnt), 64'(expRep(op, slowMul) - 1));
    repeat (expLat(op2, slowMul) + 1) @(negedge clk);
    #1;
    check(hiOut == mHi && loOut == mLo, "R8 back-to-back result", hiOut ^ loOut, mHi ^ mLo);
  endtask

  function automatic logic [63:0] pickVal();
    case ($urandom_range(7, 0))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h0000_0000_8000_0000;
      4: return {32'h0, $urandom()};
      default: return {$urandom(), $urandom()};
    endcase
  endfunction

  initial begin
    #(10 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d2c3b4a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(hiOut == 0 && loOut == 0, "R1 reset HI/LO", hiOut | loOut, 64'd0);
    check(!stallHilo && !stallBusy, "R1 reset stalls", {62'b0, stallHilo, stallBusy}, 64'd0);

    // R2 directed
    runOp(0, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5);
    runOp(1, 64'h1234_5678_FFFF_FFFF, 64'd2);
    // R3 directed
    runOp(2, 64'h8000_0000_0000_0000, '1);
    runOp(3, '1, '1);
    // R4 directed
    runOp(4, 64'hFFFF_FFF9, 64'd2);
    runOp(5, 64'hFFFF_FFF9, 64'd2);
    runOp(6, 64'h8000_0000_0000_0000, '1);
    runOp(4, 64'h8000_0000, 64'hFFFF_FFFF);
    runOp(7, '1, 64'd10);
    // R5 directed
    runOp(4, 64'h8000_0123, 64'hABCD_0000_0000_0000);
    runOp(6, 64'hDEAD_BEEF_0000_0007, 64'd0);
    // R6 directed: carry across the 32-bit boundary
    runOp(1, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    runOp(8, 64'h7FFF_FFFF, 64'h7FFF_FFFF);
    runOp(9, 64'hFFFF_FFFF, 64'd3);
    runOp(9, 64'h8000_0000, 64'h7FFF_FFFF);

    // R8 repeat windows
    runRep(0, 8, 64'd7, 64'd9);
    runRep(2, 3, 64'd11, 64'd13);
    runRep(8, 8, 64'd3, 64'd4);
    runRep(9, 0, 64'd5, 64'd6);
    runRep(5, 1, 64'd100, 64'd7);

    // R9 slow multiply mode
    slowMul = 1'b1;
    runOp(0, 64'd6, 64'd7);
    runOp(8, 64'd2, 64'd2);
    runOp(4, 64'd50, 64'd7);
    runRep(1, 9, 64'd1, 64'd2);
    runRep(3, 2, 64'd5, 64'd5);
    runRep(4, 0, 64'd9, 64'd3);
    slowMul = 1'b0;

    // R10: foreign opcode during a divide is not held and changes nothing
    @(negedge clk);
    opValid = 1'b1; opCode = 4'd6; opA = 64'd1000; opB = 64'd3;
    @(negedge clk);
    opCode = 4'd12; opA = '1; opB = '1;
    #1 check(!stallBusy && !stallHilo, "R10 foreign op not held", {62'b0, stallBusy, stallHilo}, 64'd0);
    @(negedge clk);
    opCode = 4'd15;
    #1 check(!stallBusy, "R10 foreign op not held later", {63'b0, stallBusy}, 64'd0);
    @(negedge clk);
    opValid = 1'b0;
    model(6, 64'd1000, 64'd3);
    repeat (70) @(negedge clk);
    #1 check(hiOut == mHi && loOut == mLo, "R10 foreign op ignored", loOut, mLo);
    @(negedge clk);
    opValid = 1'b1; opCode = 4'd11;
    @(negedge clk);
    opValid = 1'b0; rdHi = 1'b1;
    #1 check(!stallHilo && hiOut == mHi && loOut == mLo, "R10 idle foreign op", hiOut, mHi);
    rdHi = 1'b0;

    // random mix
    for (int i = 0; i < 200; i++) begin
      slowMul = $urandom_range(1, 0) == 1;
      runOp(int'($urandom_range(9, 0)), pickVal(), pickVal());
    end
    slowMul = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule